// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block keeps the 32-bit floating-point control and status word of a processor and updates it each time a floating-point instruction graduates. Software can load the word in one cycle and can always see its current value. The graduation side presents four things at once: the instruction class, a six-bit exception vector from the functional unit, and, for compares, a result bit with a three-bit condition-code index.

In the same cycle the block decides whether the graduating instruction must trap, and raises a trap request. On the next clock edge it updates the cause field, the sticky flags and the condition codes. The instruction class decides which exception bits count. A trap leaves the flags unchanged but still records the cause. The trap handler, the execution units and any meaning of the rounding bits are outside this block.

Top module: `fsr_unit`

## Requirements
- R1: After reset `regValue` is 0 and `trapReq` is 0.
- R2: A software write (`swWrEn`=1) makes `regValue` equal `swWrData & 32'hFF83FFFF` after the next clock edge. Bits 22:18 always read 0. The write wins over a graduation in the same cycle.
- R3: Exception vector encoding: bit 5 unimplemented, bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. In the register these map to cause bits 17..12, enable bits 11..7 and flag bits 6..2, in the same order. With `gradValid`=1, `trapReq` rises in that same cycle if the effective unimplemented bit is set, or if any other effective bit is set together with its enable bit.
- R4: Class encoding: 0 arithmetic, 1 compare, 2 move, 3 conditional move, 4 move-from, 5 load/store; codes 6 and 7 behave like load/store. Arithmetic and compare use the whole vector. Move and conditional move keep only bit 5. Move-from and load/store use none of it.
- R5: The cause field is loaded with the effective vector when an arithmetic or compare instruction graduates, or when any graduation traps. In every other case it is unchanged.
- R6: When an arithmetic or compare instruction graduates without a trap, the flags OR in effective bits 4:0. Flags never clear except by a software write. A trapping graduation leaves the flags unchanged.
- R7: A compare that does not trap writes `cmpResult` into condition code `cmpCc`. Code 0 is bit 23, and code N (1..7) is bit 24+N. A trapping compare leaves the condition codes unchanged.
- R8: Move-from and load/store graduations leave `regValue` unchanged and never request a trap.
- R9: Bits 24, 1 and 0 change only by a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 32 | Software write value |
| gradValid | input | 1 | A floating-point instruction graduates this cycle |
| gradClass | input | 3 | Instruction class code |
| gradCause | input | 6 | Exception vector from the functional unit |
| cmpResult | input | 1 | Compare outcome |
| cmpCc | input | 3 | Condition-code index of the compare |
| trapReq | output | 1 | Trap request for the graduating instruction |
| regValue | output | 32 | Current register contents |

## Verification
The layout is fixed, so the bench builds the unit with its only configuration: a 32-bit word, six causes and eight condition codes. Because that configuration is so small, the bench can cover all of it. It runs every class code against all 64 exception vectors under four enable patterns. Each vector also picks a compare result and a condition-code index, so every condition-code position is written both ways. Every trap decision, cause load, flag merge and masking rule is therefore exercised, along with the collision of a software write with a graduation.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int REG_W     = 32;
  localparam int CAUSE_W   = 6;
  localparam int ENA_W     = CAUSE_W - 1;
  localparam int CC_COUNT  = 8;
  localparam int CC_IDX_W  = $clog2(CC_COUNT);
  localparam int CAUSE_LSB = 12;
  localparam int ENA_LSB   = 7;
  localparam int FLAG_LSB  = 2;
  localparam int CC0_POS   = 23;
  localparam int CCN_BASE  = 24;
  localparam int MODE_POS  = 24;
  localparam logic [REG_W-1:0] WR_MASK = 32'hFF83FFFF;

  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_CMP   = 3'd1,
    CLS_MOV   = 3'd2,
    CLS_CMOV  = 3'd3,
    CLS_MFROM = 3'd4,
    CLS_LDST  = 3'd5
  } instClassE;

  typedef struct packed {
    logic swLoad;
    logic causeLoad;
    logic flagMerge;
    logic ccLoad;
  } fsrStrobeT;

  function automatic int ccBitPos(input int idx);
    return (idx == 0) ? CC0_POS : CCN_BASE + idx;
  endfunction
endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic               swWrEn,
  input  logic               gradValid,
  input  instClassE          gradClass,
  input  logic [CAUSE_W-1:0] gradCause,
  input  logic [ENA_W-1:0]   enables,
  output logic [CAUSE_W-1:0] effCause,
  output logic               trapReq,
  output fsrStrobeT          strobe
);
  logic arithLike;
  logic isCompare;

  always_comb begin
    effCause = '0;
    if (gradValid) begin
      unique case (gradClass)
        CLS_ARITH, CLS_CMP: effCause = gradCause;
        CLS_MOV, CLS_CMOV:  effCause = {gradCause[CAUSE_W-1], {ENA_W{1'b0}}};
        default:            effCause = '0;
      endcase
    end
  end

  assign arithLike = gradValid && ((gradClass == CLS_ARITH) || (gradClass == CLS_CMP));
  assign isCompare = gradValid && (gradClass == CLS_CMP);
  assign trapReq   = effCause[CAUSE_W-1] || (|(effCause[ENA_W-1:0] & enables));

  always_comb begin
    strobe.swLoad    = swWrEn;
    strobe.causeLoad = !swWrEn && (arithLike || trapReq);
    strobe.flagMerge = !swWrEn && arithLike && !trapReq;
    strobe.ccLoad    = !swWrEn && isCompare && !trapReq;
  end
endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fsrStrobeT           strobe,
  input  logic [REG_W-1:0]    swWrData,
  input  logic [CAUSE_W-1:0]  effCause,
  input  logic                cmpResult,
  input  logic [CC_IDX_W-1:0] cmpCc,
  output logic [ENA_W-1:0]    enables,
  output logic [REG_W-1:0]    regValue
);
  logic [CC_COUNT-1:0] ccQ;
  logic                modeQ;
  logic [CAUSE_W-1:0]  causeQ;
  logic [ENA_W-1:0]    enaQ;
  logic [ENA_W-1:0]    flagQ;
  logic [1:0]          lowQ;
  logic [REG_W-1:0]    ccView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccQ    <= '0;
      modeQ  <= 1'b0;
      causeQ <= '0;
      enaQ   <= '0;
      flagQ  <= '0;
      lowQ   <= '0;
    end else if (strobe.swLoad) begin
      for (int i = 0; i < CC_COUNT; i++) ccQ[i] <= swWrData[ccBitPos(i)];
      modeQ  <= swWrData[MODE_POS];
      causeQ <= swWrData[CAUSE_LSB +: CAUSE_W];
      enaQ   <= swWrData[ENA_LSB +: ENA_W];
      flagQ  <= swWrData[FLAG_LSB +: ENA_W];
      lowQ   <= swWrData[1:0];
    end else begin
      if (strobe.causeLoad) causeQ <= effCause;
      if (strobe.flagMerge) flagQ <= flagQ | effCause[ENA_W-1:0];
      if (strobe.ccLoad) ccQ[cmpCc] <= cmpResult;
    end
  end

  genvar g;
  generate
    for (g = 0; g < REG_W; g++) begin : gCcView
      if (g == CC0_POS) begin : gCc0
        assign ccView[g] = ccQ[0];
      end else if (g > CCN_BASE && g < CCN_BASE + CC_COUNT) begin : gCcN
        assign ccView[g] = ccQ[g - CCN_BASE];
      end else begin : gZero
        assign ccView[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    regValue = ccView;
    regValue[MODE_POS] = modeQ;
    regValue[CAUSE_LSB +: CAUSE_W] = causeQ;
    regValue[ENA_LSB +: ENA_W] = enaQ;
    regValue[FLAG_LSB +: ENA_W] = flagQ;
    regValue[1:0] = lowQ;
  end

  assign enables = enaQ;
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swWrEn,
  input  logic [31:0] swWrData,
  input  logic        gradValid,
  input  logic [2:0]  gradClass,
  input  logic [5:0]  gradCause,
  input  logic        cmpResult,
  input  logic [2:0]  cmpCc,
  output logic        trapReq,
  output logic [31:0] regValue
);
  fsrStrobeT          strobe;
  logic [CAUSE_W-1:0] effCause;
  logic [ENA_W-1:0]   enables;

  fsr_ctrl u_ctrl (
    .swWrEn    (swWrEn),
    .gradValid (gradValid),
    .gradClass (instClassE'(gradClass)),
    .gradCause (gradCause),
    .enables   (enables),
    .effCause  (effCause),
    .trapReq   (trapReq),
    .strobe    (strobe)
  );

  fsr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .swWrData  (swWrData),
    .effCause  (effCause),
    .cmpResult (cmpResult),
    .cmpCc     (cmpCc),
    .enables   (enables),
    .regValue  (regValue)
  );
endmodule

// File: rtl/fsr_unit_chk.sv
module fsr_unit_chk
  import fsr_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        swWrEn,
  input logic [31:0] swWrData,
  input logic        gradValid,
  input logic [2:0]  gradClass,
  input logic [5:0]  gradCause,
  input logic        cmpResult,
  input logic [2:0]  cmpCc,
  input logic        trapReq,
  input logic [31:0] regValue
);
  logic quietClass;
  assign quietClass = (gradClass >= 3'd4);

  // R2: software load lands on the next edge, masked
  a_r2_sw_load: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> regValue == ($past(swWrData) & WR_MASK));

  // R2: unused bits stay zero
  a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    regValue[22:18] == 5'b0);

  // R3: unimplemented always traps for classes that keep it
  a_r3_unimpl_traps: assert property (@(posedge clk) disable iff (!rstN)
    (gradValid && gradClass <= 3'd3 && gradCause[5]) |-> trapReq);

  // R8: quiet classes never trap and never change the word
  a_r8_quiet_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (gradValid && quietClass) |-> !trapReq);
  a_r8_quiet_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && (!gradValid || quietClass)) |=> $stable(regValue));

  // R6: flags are sticky without a software write
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> ((regValue[6:2] & $past(regValue[6:2])) == $past(regValue[6:2])));

  // R6: trapping graduation leaves the flags alone
  a_r6_trap_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && gradValid && trapReq) |=> $stable(regValue[6:2]));

  // R5: non-trapping arithmetic records its full vector
  a_r5_arith_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && gradValid && gradClass == 3'd0) |=> regValue[17:12] == $past(gradCause));

  // R9: mode and low bits move only by software
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    !swWrEn |=> ($stable(regValue[24]) && $stable(regValue[1:0])));
endmodule

bind fsr_unit fsr_unit_chk u_chk (.*);

// File: tb/fsr_unit_tb.sv
module fsr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        gradValid = 1'b0;
  logic [2:0]  gradClass = '0;
  logic [5:0]  gradCause = '0;
  logic        cmpResult = 1'b0;
  logic [2:0]  cmpCc = '0;
  logic        trapReq;
  logic [31:0] regValue;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] expReg = '0;

  localparam logic [31:0] MASK = 32'hFF83FFFF;

  always #2 clk = ~clk;

  fsr_unit u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // R4 effective vector per class
  function automatic logic [5:0] effOf(input logic [2:0] cls, input logic [5:0] c);
    if (cls <= 3'd1) return c;
    if (cls <= 3'd3) return {c[5], 5'b0};
    return 6'b0;
  endfunction

  // R3 trap decision
  function automatic logic trapOf(input logic [31:0] r, input logic [2:0] cls, input logic [5:0] c);
    logic [5:0] e;
    e = effOf(cls, c);
    return e[5] | (|(e[4:0] & r[11:7]));
  endfunction

  // R5, R6, R7, R8 next register value
  function automatic logic [31:0] nextOf(input logic [31:0] r, input logic [2:0] cls,
                                         input logic [5:0] c, input logic res, input logic [2:0] cc);
    logic [5:0] e;
    logic t;
    logic [31:0] n;
    e = effOf(cls, c);
    t = trapOf(r, cls, c);
    n = r;
    if (cls <= 3'd1 || t) n[17:12] = e;
    if (cls <= 3'd1 && !t) n[6:2] = r[6:2] | e[4:0];
    if (cls == 3'd1 && !t) n[(cc == 0) ? 23 : 24 + int'(cc)] = res;
    return n;
  endfunction

  task automatic swWrite(input logic [31:0] d);
    @(negedge clk);
    swWrEn = 1'b1;
    swWrData = d;
    @(posedge clk);
    #1;
    swWrEn = 1'b0;
    expReg = d & MASK;
    check("R2 write", regValue, expReg);
  endtask

  task automatic grad(input logic [2:0] cls, input logic [5:0] c, input logic res, input logic [2:0] cc);
    @(negedge clk);
    gradValid = 1'b1;
    gradClass = cls;
    gradCause = c;
    cmpResult = res;
    cmpCc = cc;
    #1;
    check("R3/R4/R8 trap", {31'b0, trapReq}, {31'b0, trapOf(expReg, cls, c)});
    @(posedge clk);
    #1;
    gradValid = 1'b0;
    expReg = nextOf(expReg, cls, c, res, cc);
    check("R5/R6/R7/R8/R9 update", regValue, expReg);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] enaSet [4];
    enaSet[0] = 5'h00; enaSet[1] = 5'h1F; enaSet[2] = 5'h15; enaSet[3] = 5'h0A;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", regValue, 32'h0);
    check("R1 reset trap", {31'b0, trapReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 gap bits read zero
    swWrite(32'hFFFFFFFF);
    check("R2 mask", regValue, 32'hFF83FFFF);

    for (int e = 0; e < 4; e++) begin
      for (int cls = 0; cls < 8; cls++) begin
        // R9 mode and low bits set; flags cleared by the write
        swWrite({8'hA5, 1'b1, 5'b0, 6'b0, enaSet[e], 5'b0, 2'b11} | 32'h01000003);
        for (int c = 0; c < 64; c++) begin
          grad(3'(cls), 6'(c), c[0], 3'(c >> 1));
        end
      end
    end

    // R2 write wins over a graduation in the same cycle
    swWrite(32'h00000F80);
    @(negedge clk);
    swWrEn = 1'b1;
    swWrData = 32'h12345678;
    gradValid = 1'b1;
    gradClass = 3'd0;
    gradCause = 6'h1F;
    #1;
    check("R3 trap with write", {31'b0, trapReq}, 32'h1);
    @(posedge clk);
    #1;
    swWrEn = 1'b0;
    gradValid = 1'b0;
    expReg = 32'h12345678 & MASK;
    check("R2 write priority", regValue, expReg);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule